// File: doc/BRIEF.md
# Shadowed PWM Compare Event Unit

This block is the timing core of one PWM timer channel pair. A 16-bit time-base counter runs in one of four count modes against a programmable period: up, down, up-down or frozen. Two compare channels, A and B, each hold an active compare value. Whenever the counter equals a channel's active value, that channel raises its match event in the same cycle. The block also flags the cycles in which the counter sits at zero or at the period. A following action stage consumes these events together with the reported count direction.

Each channel also holds a shadow copy that shares the channel's single register address. A per-channel mode bit decides which copy a register access reaches. In shadow mode, software writes the shadow copy, and hardware moves it into the active copy only at the zero event, the period event or either of them. The active copy therefore never changes in the middle of a PWM period. In immediate mode, accesses go straight to the active copy.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset the count is 0, `dir_down` is 0, and both the active and the shadow copies of both channels hold 0.
- R2: With `cnt_mode`=00 (up), the count steps by +1 each clock until it reaches `period`, then returns to 0 on the next clock. `dir_down` is 0.
- R3: With `cnt_mode`=01 (down), the count steps by -1 each clock until it reaches 0, then reloads `period` on the next clock. `dir_down` is 1.
- R4: With `cnt_mode`=10 (up-down), the count rises from 0 to `period` and falls back again, turning at each end, so one cycle lasts 2*`period` clocks. `dir_down` gives the direction of the step that produced the current count, so it is high in `period` of those clocks.
- R5: With `cnt_mode`=11, the count holds its value.
- R6: `ev_zero` is high exactly in the cycles where the count is 0. `ev_prd` is high exactly in the cycles where the count equals `period`.
- R7: `ev_cmp_a` and `ev_cmp_b` are high in the cycles where the count equals that channel's active value. This gives one event per counter cycle in up and down modes. In up-down mode it gives two events per cycle for a value strictly between 0 and `period`, and one event for a value of 0 or `period`.
- R8: The register port selects the channel with `reg_sel` (0 = A, 1 = B). When the channel's bit in `shadow_off` is 1, `reg_wr` writes `reg_wdata` to the active copy and `reg_rdata` returns the active copy. When the bit is 0, both the write and the read use the shadow copy.
- R9: A shadow value never produces a match event, even when it equals the count.
- R10: In shadow mode, the 2-bit load select (`ld_mode_a`/`ld_mode_b`) picks when the shadow copy moves into the active copy: 00 = on the zero event, 01 = on the period event, 10 = on either event, 11 = never.
- R11: A shadow transfer triggered by an event takes effect from the next clock. The match in the event's own cycle still uses the old active value.
- R12: Accesses and transfers on one channel leave the other channel's values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_mode | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 frozen |
| period | input | 16 | Counter period (top value) |
| shadow_off | input | 2 | Per channel (bit 0 = A, bit 1 = B): 1 selects immediate access, 0 selects shadow mode |
| ld_mode_a | input | 2 | Shadow load select for channel A |
| ld_mode_b | input | 2 | Shadow load select for channel B |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = A, 1 = B |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register copy |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 when the last counter step was downward |
| ev_zero | output | 1 | Counter equals zero |
| ev_prd | output | 1 | Counter equals period |
| ev_cmp_a | output | 1 | Counter equals active value A |
| ev_cmp_b | output | 1 | Counter equals active value B |

## Verification
The sharpest corner is the timing of the shadow transfer. Old active value 4 and new shadow value 0 are staged in the middle of a period, and the bench looks at the next zero of the count for each load select. A design that transfers in the same cycle as the event, that decodes the select fields wrongly, or that ignores the "never" code gives the wrong match at that zero. The bench counts events over exact whole counter cycles, so an up-down counter that turns one step late or early, or that fires a compare twice at an endpoint, shows a wrong event count. A shadow value equal to the frozen count checks that the compare never looks at the shadow copy. Wrap and reload checks at the counter's ends catch off-by-one errors in the period handling.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    LD_ZERO = 2'b00,
    LD_PRD  = 2'b01,
    LD_BOTH = 2'b10,
    LD_NONE = 2'b11
  } load_sel_e;

  // Decide whether a shadow transfer is due in this cycle.
  function automatic logic load_due(input logic [1:0] sel,
                                    input logic at_zero,
                                    input logic at_prd);
    unique case (load_sel_e'(sel))
      LD_ZERO: return at_zero;
      LD_PRD:  return at_prd;
      LD_BOTH: return at_zero | at_prd;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          dir_down,
  output logic          at_zero,
  output logic          at_prd
);

  // Returns {next_dir_down, next_count}.
  function automatic logic [CW:0] tb_step(input logic [1:0] m, input logic d,
                                          input logic [CW-1:0] c,
                                          input logic [CW-1:0] p);
    logic [CW-1:0] n;
    logic          nd;
    n  = c;
    nd = d;
    unique case (cnt_mode_e'(m))
      CM_UP: begin
        nd = 1'b0;
        n  = (c >= p) ? '0 : c + 1'b1;
      end
      CM_DOWN: begin
        nd = 1'b1;
        n  = (c == '0) ? p : c - 1'b1;
      end
      CM_UPDN: begin
        if (!d) begin
          if (c >= p) begin
            nd = 1'b1;
            n  = (c == '0) ? c : c - 1'b1;
          end else begin
            n = c + 1'b1;
          end
        end else begin
          if (c == '0) begin
            nd = 1'b0;
            n  = (p == '0) ? c : c + 1'b1;
          end else begin
            n = c - 1'b1;
          end
        end
      end
      default: ;
    endcase
    return {nd, n};
  endfunction

  logic [CW:0] nxt;
  assign nxt = tb_step(mode, dir_down, count, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else begin
      count    <= nxt[CW-1:0];
      dir_down <= nxt[CW];
    end
  end

  assign at_zero = (count == '0);
  assign at_prd  = (count == period);

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && count >= period) |=> (count == '0 && !dir_down));

  // R3
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_DOWN && count == '0) |=> (count == $past(period) && dir_down));

  // R4
  updn_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UPDN && !dir_down && count != '0 && count >= period) |=> dir_down);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD) |=> $stable(count));

endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imm,
  input  logic [1:0]    load_sel,
  input  logic          at_zero,
  input  logic          at_prd,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] rdata,
  output logic          match
);

  logic [CW-1:0] active_q;
  logic [CW-1:0] shadow_q;
  logic          load_now;

  assign load_now = !imm && load_due(load_sel, at_zero, at_prd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      shadow_q <= '0;
    end else begin
      if (imm) begin
        if (wr_en) active_q <= wdata;
      end else begin
        if (wr_en)    shadow_q <= wdata;
        if (load_now) active_q <= shadow_q;
      end
    end
  end

  assign rdata = imm ? active_q : shadow_q;
  assign match = (count == active_q);

  // R10
  shadow_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (active_q == $past(shadow_q)));

  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm && !load_now) |=> $stable(active_q));

  // R8
  imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm && wr_en) |=> (active_q == $past(wdata)));

  // R8
  imm_shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm |=> $stable(shadow_q));

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cnt_mode,
  input  logic [CW-1:0] period,
  input  logic [1:0]    shadow_off,
  input  logic [1:0]    ld_mode_a,
  input  logic [1:0]    ld_mode_b,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic [CW-1:0] count,
  output logic          dir_down,
  output logic          ev_zero,
  output logic          ev_prd,
  output logic          ev_cmp_a,
  output logic          ev_cmp_b
);

  localparam int NCH = 2;

  logic [1:0]    ld_sel [NCH];
  logic [CW-1:0] rd     [NCH];
  logic [NCH-1:0] hit;

  assign ld_sel[0] = ld_mode_a;
  assign ld_sel[1] = ld_mode_b;

  pwm_timebase #(.CW(CW)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cnt_mode),
    .period   (period),
    .count    (count),
    .dir_down (dir_down),
    .at_zero  (ev_zero),
    .at_prd   (ev_prd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_here;
    assign wr_here = reg_wr && (reg_sel == 1'(i));
    pwm_cmp_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .imm      (shadow_off[i]),
      .load_sel (ld_sel[i]),
      .at_zero  (ev_zero),
      .at_prd   (ev_prd),
      .wr_en    (wr_here),
      .wdata    (reg_wdata),
      .count    (count),
      .rdata    (rd[i]),
      .match    (hit[i])
    );
  end

  assign reg_rdata = rd[reg_sel];
  assign ev_cmp_a  = hit[0];
  assign ev_cmp_b  = hit[1];

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == CM_UP && ev_prd) |=> ev_zero);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !dir_down));

endmodule

// File: tb/pwm_cmp_unit_tb.sv
module pwm_cmp_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cnt_mode;
  logic [15:0] period;
  logic [1:0]  shadow_off;
  logic [1:0]  ld_mode_a, ld_mode_b;
  logic        reg_wr, reg_sel;
  logic [15:0] reg_wdata, reg_rdata, count;
  logic        dir_down, ev_zero, ev_prd, ev_cmp_a, ev_cmp_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .period(period),
    .shadow_off(shadow_off), .ld_mode_a(ld_mode_a), .ld_mode_b(ld_mode_b),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .dir_down(dir_down),
    .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_count(input int v);
    for (int k = 0; k < 200; k++) begin
      if (count == 16'(v)) return;
      @(negedge clk);
    end
  endtask

  task automatic wr_reg(input bit sel, input int val);
    reg_sel = sel; reg_wdata = 16'(val); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input bit sel, output int val);
    reg_sel = sel;
    #1;
    val = int'(reg_rdata);
  endtask

  // Count event cycles over a window of n clocks.
  task automatic tally(input int n, output int na, output int nb,
                       output int nz, output int np, output int nd);
    na = 0; nb = 0; nz = 0; np = 0; nd = 0;
    for (int k = 0; k < n; k++) begin
      na += int'(ev_cmp_a); nb += int'(ev_cmp_b);
      nz += int'(ev_zero);  np += int'(ev_prd); nd += int'(dir_down);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    chk(count == 0, "R1 count", int'(count), 0);
    chk(dir_down == 0, "R1 dir", int'(dir_down), 0);
    rd_reg(0, v); chk(v == 0, "R1 shadow A", v, 0);
    rd_reg(1, v); chk(v == 0, "R1 shadow B", v, 0);
    chk(ev_cmp_a == 1 && ev_cmp_b == 1, "R1 active zero", int'(ev_cmp_a), 1);
    chk(ev_zero == 1, "R6 zero flag", int'(ev_zero), 1);
  endtask

  task automatic t_regport();
    int v;
    shadow_off = 2'b01;
    wr_reg(0, 9);
    rd_reg(0, v); chk(v == 9, "R8 imm readback", v, 9);
    shadow_off = 2'b00;
    wr_reg(0, 0);
    rd_reg(0, v); chk(v == 0, "R8 shadow readback", v, 0);
    step(2);
    // count held at 0, shadow A = 0, active A = 9
    chk(ev_cmp_a == 0, "R9 shadow no match", int'(ev_cmp_a), 0);
    shadow_off = 2'b01;
    rd_reg(0, v); chk(v == 9, "R8 active kept", v, 9);
  endtask

  task automatic t_up();
    int na, nb, nz, np, nd;
    period = 5; shadow_off = 2'b11;
    wr_reg(0, 3); wr_reg(1, 5);
    cnt_mode = 2'b00;
    step(3);
    tally(12, na, nb, nz, np, nd);
    chk(na == 2, "R7 up A", na, 2);
    chk(nb == 2, "R7 up B", nb, 2);
    chk(nz == 2 && np == 2, "R6 up flags", nz * 10 + np, 22);
    chk(nd == 0, "R2 dir", nd, 0);
    wait_count(5); step(1);
    chk(count == 0, "R2 wrap", int'(count), 0);
  endtask

  task automatic t_down();
    int na, nb, nz, np, nd;
    cnt_mode = 2'b01;
    step(3);
    tally(12, na, nb, nz, np, nd);
    chk(na == 2, "R7 down A", na, 2);
    chk(nd == 12, "R3 dir", nd, 12);
    wait_count(0); step(1);
    chk(count == 5, "R3 reload", int'(count), 5);
    step(1);
    chk(count == 4, "R3 decrement", int'(count), 4);
  endtask

  task automatic t_updown();
    int na, nb, nz, np, nd;
    period = 4;
    wr_reg(0, 2); wr_reg(1, 4);
    cnt_mode = 2'b10;
    step(12);
    tally(16, na, nb, nz, np, nd);
    chk(na == 4, "R7 updown interior", na, 4);
    chk(nb == 2, "R7 updown endpoint", nb, 2);
    chk(nz == 2 && np == 2, "R6 updown flags", nz * 10 + np, 22);
    chk(nd == 8, "R4 dir cycles", nd, 8);
    wait_count(4); step(1);
    chk(count == 3 && dir_down == 1, "R4 turn at period", int'(count), 3);
  endtask

  task automatic t_hold();
    int v;
    cnt_mode = 2'b11;
    step(1);
    v = int'(count);
    step(4);
    chk(int'(count) == v, "R5 frozen", int'(count), v);
  endtask

  // Active A = 4, shadow A = 0 staged; look at the next two zero counts.
  task automatic t_load(input logic [1:0] sel, input int exp1, input int exp2);
    int v;
    period = 5; cnt_mode = 2'b00; ld_mode_a = 2'b11;
    shadow_off = 2'b11;
    wr_reg(0, 4);
    shadow_off = 2'b10;
    wr_reg(0, 0);
    wait_count(2);
    ld_mode_a = sel;
    wait_count(0);
    chk(int'(ev_cmp_a) == exp1, $sformatf("R11 first zero sel=%0d", sel), int'(ev_cmp_a), exp1);
    step(1); wait_count(0);
    chk(int'(ev_cmp_a) == exp2, $sformatf("R10 second zero sel=%0d", sel), int'(ev_cmp_a), exp2);
    rd_reg(1, v);
    chk(v == 4, "R12 B untouched", v, 4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; cnt_mode = 2'b11; period = 5; shadow_off = 2'b00;
    ld_mode_a = 2'b11; ld_mode_b = 2'b11;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_regport();
    t_up();
    t_down();
    t_updown();
    t_hold();
    t_load(2'b00, 0, 1);
    t_load(2'b01, 1, 1);
    t_load(2'b10, 1, 1);
    t_load(2'b11, 0, 0);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule